// File: doc/BRIEF.md
# Quadrant write-protection controller

This block guards a 512-byte nonvolatile array that is split into four 128-byte quadrants. Each quadrant owns one lock bit. The serial front end decodes protection commands and passes them in, together with a digital flag. The flag is high while the high programming voltage is detected on the lowest device-address pin. A lock can be set for one quadrant at a time. All locks can only be removed together, by one clear command. Both actions take effect only while the voltage flag is high. Any quadrant's state can be queried at any time.

Every command is answered one clock later with an acknowledge or a not-acknowledge. The front end returns that answer on the bus. During a write, the front end presents each byte's 9-bit effective address. The block answers at once, in the same cycle, whether that byte may be written. Each byte of a page write is therefore judged on its own.

The lock bits stand for nonvolatile cells. They start unlocked at power-up and are not touched by the synchronous reset, so a reset leaves the protection state unchanged.

Top module: `quad_wprot`

## Requirements
- R1: After power-up all four quadrants are unlocked. `wr_allow` is 1 for every address, and a query of any quadrant is answered with a not-acknowledge.
- R2: A set command (`cmd_op` = 2'b01) for quadrant `cmd_quad`, issued with `hv_present` = 1, is answered with an acknowledge. From the next cycle on, that quadrant is locked and the other quadrants keep their state.
- R3: A set command issued with `hv_present` = 0 is answered with a not-acknowledge and leaves all four lock bits unchanged.
- R4: A clear command (`cmd_op` = 2'b10), issued with `hv_present` = 1, is answered with an acknowledge. It unlocks all four quadrants at once, from the next cycle on.
- R5: A clear command issued with `hv_present` = 0 is answered with a not-acknowledge and leaves all lock bits unchanged.
- R6: A query (`cmd_op` = 2'b11) of quadrant `cmd_quad` is answered with an acknowledge if that quadrant is locked and with a not-acknowledge if it is not, whatever the level of `hv_present`. A query changes no lock.
- R7: `wr_allow` is 0 exactly when the quadrant selected by address bits [8:7] (the page-select bit and word bit 7) is locked. The output follows `wr_addr` in the same cycle, with no register on the way.
- R8: While `rst` is 1, `rsp_valid` is 0 and commands are ignored. The lock bits keep their values through reset.
- R9: The reserved code `cmd_op` = 2'b00 is answered with a not-acknowledge and changes no lock.
- R10: Each cycle with `cmd_valid` = 1 produces exactly one cycle of `rsp_valid` = 1, on the next clock edge. `rsp_ack` = 1 means acknowledge and is only ever 1 together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the response path |
| cmd_valid | input | 1 | A protection command is presented this cycle |
| cmd_op | input | 2 | Command code: 00 reserved, 01 set, 10 clear all, 11 query |
| cmd_quad | input | 2 | Quadrant targeted by a set or a query |
| hv_present | input | 1 | High programming voltage detected on the address pin |
| wr_addr | input | 9 | Effective address of the byte about to be written |
| wr_allow | output | 1 | 1 when the byte at `wr_addr` may be written |
| rsp_valid | output | 1 | Answer to the previous cycle's command is present |
| rsp_ack | output | 1 | 1 = acknowledge, 0 = not-acknowledge |

## Verification
The bench builds the block with its default parameters: a 9-bit address and four quadrants. This puts every quadrant index and every quadrant boundary of the full 512-byte space within reach, including the step from address 255 to 256, where the page-select bit changes. The vector walk and the directed tests run the following patterns:
- sets with and without the voltage flag;
- a repeated set of the same quadrant;
- clears with and without the voltage flag;
- the reserved command code;
- back-to-back commands.

The directed tests also hold a command through a reset and then check that the locks survive it.

// File: rtl/quad_wprot_pkg.sv
package quad_wprot_pkg;

  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_NONE  = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_QUERY = 2'b11
  } wp_op_e;

endpackage

// File: rtl/quad_wprot_decode.sv
module quad_wprot_decode
  import quad_wprot_pkg::*;
#(
  parameter int NUM_QUAD = 4,
  localparam int QUAD_W  = $clog2(NUM_QUAD)
) (
  input  logic                go,
  input  wp_op_e              op,
  input  logic [QUAD_W-1:0]   quad,
  input  logic                hv,
  input  logic [NUM_QUAD-1:0] locks,
  output logic [NUM_QUAD-1:0] set_mask,
  output logic                clr_all,
  output logic                ack
);

  logic set_go;

  always_comb begin
    set_go  = 1'b0;
    clr_all = 1'b0;
    ack     = 1'b0;
    if (go) begin
      unique case (op)
        OP_SET: begin
          set_go = hv;
          ack    = hv;
        end
        OP_CLEAR: begin
          clr_all = hv;
          ack     = hv;
        end
        OP_QUERY: ack = locks[quad];
        default:  ack = 1'b0;
      endcase
    end
  end

  for (genvar q = 0; q < NUM_QUAD; q++) begin : g_sel
    assign set_mask[q] = set_go && (quad == QUAD_W'(q));
  end

endmodule

// File: rtl/quad_wprot_lock_bank.sv
module quad_wprot_lock_bank #(
  parameter int NUM_QUAD = 4
) (
  input  logic                clk,
  input  logic [NUM_QUAD-1:0] set_mask,
  input  logic                clr_all,
  output logic [NUM_QUAD-1:0] locks
);

  for (genvar q = 0; q < NUM_QUAD; q++) begin : g_cell
    logic cell_q = 1'b0;
    always_ff @(posedge clk) begin
      if (clr_all)          cell_q <= 1'b0;
      else if (set_mask[q]) cell_q <= 1'b1;
    end
    assign locks[q] = cell_q;
  end

endmodule

// File: rtl/quad_wprot_addr_check.sv
module quad_wprot_addr_check #(
  parameter int NUM_QUAD = 4,
  localparam int QUAD_W  = $clog2(NUM_QUAD)
) (
  input  logic [QUAD_W-1:0]   quad_idx,
  input  logic [NUM_QUAD-1:0] locks,
  output logic                allow
);

  logic [NUM_QUAD-1:0] hit;

  for (genvar q = 0; q < NUM_QUAD; q++) begin : g_hit
    assign hit[q] = (quad_idx == QUAD_W'(q)) && locks[q];
  end

  assign allow = ~|hit;

endmodule

// File: rtl/quad_wprot.sv
module quad_wprot
  import quad_wprot_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int NUM_QUAD = 4,
  localparam int QUAD_W  = $clog2(NUM_QUAD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [QUAD_W-1:0] cmd_quad,
  input  logic              hv_present,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_allow,
  output logic              rsp_valid,
  output logic              rsp_ack
);

  logic [NUM_QUAD-1:0] locks;
  logic [NUM_QUAD-1:0] set_mask;
  logic                clr_all;
  logic                ack_d;
  logic                go;
  logic                unused_low;

  // Commands are gated off while reset is held; locks are outside reset.
  assign go         = cmd_valid && !rst;
  assign unused_low = ^wr_addr[ADDR_W-QUAD_W-1:0];

  quad_wprot_decode #(.NUM_QUAD(NUM_QUAD)) decode_i (
    .go       (go),
    .op       (wp_op_e'(cmd_op)),
    .quad     (cmd_quad),
    .hv       (hv_present),
    .locks    (locks),
    .set_mask (set_mask),
    .clr_all  (clr_all),
    .ack      (ack_d)
  );

  quad_wprot_lock_bank #(.NUM_QUAD(NUM_QUAD)) bank_i (
    .clk      (clk),
    .set_mask (set_mask),
    .clr_all  (clr_all),
    .locks    (locks)
  );

  quad_wprot_addr_check #(.NUM_QUAD(NUM_QUAD)) check_i (
    .quad_idx (wr_addr[ADDR_W-1 -: QUAD_W]),
    .locks    (locks),
    .allow    (wr_allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_ack   <= go && ack_d;
    end
  end

endmodule

// File: rtl/quad_wprot_chk.sv
module quad_wprot_chk
  import quad_wprot_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [OP_W-1:0]   cmd_op,
  input logic              hv_present,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_allow,
  input logic              rsp_valid,
  input logic              rsp_ack
);

  p_rsp_follows_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);

  p_no_rsp_without_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);

  p_ack_implies_valid_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |-> rsp_valid);

  p_set_hv_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && hv_present && cmd_op == OP_SET) |=> rsp_ack);

  p_nohv_nack_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !hv_present && cmd_op != OP_QUERY) |=> !rsp_ack);

  p_nohv_keeps_locks_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !hv_present && cmd_op != OP_QUERY)
      |=> ($stable(wr_addr) -> $stable(wr_allow)));

  p_clear_unlocks_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && hv_present && cmd_op == OP_CLEAR) |=> (rsp_ack && wr_allow));

  p_query_keeps_locks_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_QUERY) |=> ($stable(wr_addr) -> $stable(wr_allow)));

  p_reserved_nack_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_NONE) |=> !rsp_ack);

endmodule

bind quad_wprot quad_wprot_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .hv_present (hv_present),
  .wr_addr    (wr_addr),
  .wr_allow   (wr_allow),
  .rsp_valid  (rsp_valid),
  .rsp_ack    (rsp_ack)
);

// File: tb/quad_wprot_tb_top.sv
`timescale 1ns/1ps
module quad_wprot_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_quad = 2'b00;
  logic       hv_present = 1'b0;
  logic [8:0] wr_addr = 9'd0;
  logic       wr_allow, rsp_valid, rsp_ack;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  quad_wprot dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_quad(cmd_quad), .hv_present(hv_present), .wr_addr(wr_addr),
    .wr_allow(wr_allow), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
  );

  // Vector: op[9:8] quad[7:6] hv[5] expected ack[4] expected lock mask[3:0]
  localparam int NVEC = 15;
  localparam logic [9:0] VEC [NVEC] = '{
    {2'b11, 2'd0, 1'b0, 1'b0, 4'b0000},  // query q0, unlocked
    {2'b01, 2'd1, 1'b0, 1'b0, 4'b0000},  // set q1 without hv
    {2'b01, 2'd1, 1'b1, 1'b1, 4'b0010},  // set q1
    {2'b11, 2'd1, 1'b0, 1'b1, 4'b0010},  // query q1, locked
    {2'b11, 2'd2, 1'b0, 1'b0, 4'b0010},  // query q2, unlocked
    {2'b01, 2'd3, 1'b1, 1'b1, 4'b1010},  // set q3
    {2'b01, 2'd3, 1'b1, 1'b1, 4'b1010},  // set q3 again
    {2'b10, 2'd0, 1'b0, 1'b0, 4'b1010},  // clear without hv
    {2'b00, 2'd1, 1'b1, 1'b0, 4'b1010},  // reserved code
    {2'b01, 2'd0, 1'b1, 1'b1, 4'b1011},  // set q0
    {2'b01, 2'd2, 1'b1, 1'b1, 4'b1111},  // set q2
    {2'b11, 2'd2, 1'b1, 1'b1, 4'b1111},  // query q2 with hv
    {2'b10, 2'd3, 1'b1, 1'b1, 4'b0000},  // clear all
    {2'b11, 2'd3, 1'b0, 1'b0, 4'b0000},  // query q3 after clear
    {2'b01, 2'd2, 1'b1, 1'b1, 4'b0100}   // set q2, kept for reset test
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R7: probe one address inside each quadrant
  task automatic check_locks(input string tag, input logic [3:0] mask);
    for (int q = 0; q < 4; q++) begin
      wr_addr = 9'(q * 128 + 17 * q + 3);
      #0.2;
      chk(tag, {31'd0, wr_allow}, {31'd0, !mask[q]});
    end
  endtask

  // Drive a command for one cycle; check the answer one edge later.
  task automatic issue(input logic [1:0] op, input logic [1:0] quad, input logic hv,
                       input logic exp_ack, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_quad = quad; hv_present = hv;
    @(negedge clk);
    cmd_valid = 1'b0; hv_present = 1'b0;
    chk({tag, " R10 rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    chk(tag, {31'd0, rsp_ack}, {31'd0, exp_ack});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8 / R1: reset state
    repeat (3) @(negedge clk);
    chk("R8 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    check_locks("R1 power-up unlocked", 4'b0000);

    // Vector walk covering R2 R3 R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][9:8], VEC[i][7:6], VEC[i][5], VEC[i][4], $sformatf("R2-R9 vec%0d ack", i));
      check_locks($sformatf("R2 R3 R5 vec%0d locks", i), VEC[i][3:0]);
    end
    @(negedge clk);
    chk("R10 single response", {31'd0, rsp_valid}, 32'd0);

    // R7: same-cycle response across quadrant boundaries (q2 locked)
    wr_addr = 9'd255; #0.2; chk("R7 addr 255", {31'd0, wr_allow}, 32'd1);
    wr_addr = 9'd256; #0.2; chk("R7 addr 256", {31'd0, wr_allow}, 32'd0);
    wr_addr = 9'd383; #0.2; chk("R7 addr 383", {31'd0, wr_allow}, 32'd0);
    wr_addr = 9'd384; #0.2; chk("R7 addr 384", {31'd0, wr_allow}, 32'd1);

    // R8: command during reset ignored, locks retained
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b1; cmd_op = 2'b01; cmd_quad = 2'd0; hv_present = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 rsp_valid held low", {31'd0, rsp_valid}, 32'd0);
    rst = 1'b0; cmd_valid = 1'b0; hv_present = 1'b0;
    @(negedge clk);
    check_locks("R8 locks kept through reset", 4'b0100);
    issue(2'b11, 2'd2, 1'b0, 1'b1, "R6 R8 query q2 after reset");

    // R10 / R6: back-to-back set then query
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_quad = 2'd0; hv_present = 1'b1;
    @(negedge clk);
    cmd_op = 2'b11; hv_present = 1'b0;
    chk("R10 b2b first ack", {31'd0, rsp_ack}, 32'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 b2b second valid", {31'd0, rsp_valid}, 32'd1);
    chk("R6 b2b query sees new lock", {31'd0, rsp_ack}, 32'd1);
    check_locks("R2 b2b locks", 4'b0101);

    // R4: clear with hv, then reserved code leaves all unlocked
    issue(2'b10, 2'd1, 1'b1, 1'b1, "R4 clear");
    check_locks("R4 all cleared", 4'b0000);
    issue(2'b00, 2'd2, 1'b1, 1'b0, "R9 reserved");
    check_locks("R9 no change", 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule